// File: doc/BRIEF.md
# Test-Port Data Register Selector with Configuration Gating

This block sits behind the instruction register of a JTAG test port. It takes the instruction that is currently in force and picks the data register that sits between TDI and TDO. The choices are a one-bit bypass stage, a separate one-bit stage for the configuration no-operation, a fixed 32-bit identification chain, and a 32-bit user-code chain. The block also keeps a flag that records whether in-system configuration is open. The configuration instructions act only while that flag is set.

Two registered outputs go to the rest of the chip. The first tells the pad logic that the boundary register, not system logic, drives the output pins. The second lets the configuration-memory write path run. The user code resets to the identification value with its 11-bit manufacturer field cleared. The code can be replaced by a serial write, which takes effect only while configuration is open.

All strobes come from the TAP controller as single-cycle pulses in the clock domain of the block. Reset is synchronous and active high.

Top module: `isc_tap_dr_sel`

## Requirements
- R1: After reset the configuration-open flag is clear, `prog_en` and `bsr_owns_pads` are 0, and the stored user code equals its default.
- R2: With instruction 4'h1, a capture loads the identification value. TDO then shows the value LSB first, one bit per shift, and bit 0 is 1.
- R3: The default user code equals the identification value with bits [11:1] forced to 0. Instruction 4'h2 with a capture and 32 shifts reads it out LSB first.
- R4: With configuration open and instruction 4'h7, 32 bits shifted in LSB first and followed by an update strobe replace the stored user code. A later read under 4'h2 returns the new value.
- R5: With configuration closed, instruction 4'h7 selects the one-bit bypass path. The shift and update that follow leave the stored user code unchanged.
- R6: An instruction-update strobe with code 4'h3 opens configuration. One with code 4'h4 closes it. Codes 4'h5, 4'h6 and 4'h7 act only while configuration is open.
- R7: Code 4'h5, with configuration open, routes TDI to TDO through a one-bit stage that captures 0. One clock after the code is applied, `bsr_owns_pads` is 1.
- R8: Code 4'hF and every code with no defined meaning select the one-bit bypass stage, which captures 0 and delays TDI by one shift. `bsr_owns_pads` stays 0.
- R9: One clock after code 4'h6 is applied with configuration open, `prog_en` goes to 1. `prog_en` is 0 for any other code, and it is 0 while configuration is closed.
- R10: `bsr_owns_pads` is 1 exactly while configuration is open and the code is 4'h5, 4'h6 or 4'h7. It follows the code with one clock of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test-port clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_upd | input | 1 | Strobe marking a newly updated instruction |
| instr | input | 4 | Instruction code in force |
| capture_dr | input | 1 | Data-register capture strobe |
| shift_dr | input | 1 | Data-register shift strobe |
| update_dr | input | 1 | Data-register update strobe |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, LSB of the selected chain |
| bsr_owns_pads | output | 1 | Boundary register drives the output pins |
| prog_en | output | 1 | Configuration programming allowed |

## Verification
A configuration-open flag in the wrong state shows at the ports within one clock of the next instruction. `prog_en` or `bsr_owns_pads` takes the wrong level, and the chain length seen at TDO changes between one and 32 bits. A stored user code that was corrupted, or written without permission, stays hidden until the next user-code read. That read exposes it within 32 shifts, so each write attempt in the bench is followed by such a read.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int IR_W = 4;
  typedef logic [IR_W-1:0] ir_t;

  localparam ir_t IR_IDCODE   = 4'h1;
  localparam ir_t IR_USERCODE = 4'h2;
  localparam ir_t IR_ISC_EN   = 4'h3;
  localparam ir_t IR_ISC_DIS  = 4'h4;
  localparam ir_t IR_ISC_NOOP = 4'h5;
  localparam ir_t IR_ISC_PROG = 4'h6;
  localparam ir_t IR_ISC_PUC  = 4'h7;
  localparam ir_t IR_BYPASS   = 4'hF;

  typedef enum logic [1:0] {
    PATH_BYP  = 2'd0,
    PATH_NOOP = 2'd1,
    PATH_ID   = 2'd2,
    PATH_USER = 2'd3
  } path_e;
endpackage

// File: rtl/isc_instr_decode.sv
module isc_instr_decode
  import isc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  ir_upd,
  input  ir_t   instr,
  output path_e path,
  output logic  isc_active,
  output logic  ucode_wr_ok,
  output logic  pads_q,
  output logic  prog_q
);
  logic pads_d, prog_d, isc_cmd;

  // configuration window flag
  always_ff @(posedge clk) begin
    if (rst) begin
      isc_active <= 1'b0;
    end else if (ir_upd) begin
      if (instr == IR_ISC_EN) begin
        isc_active <= 1'b1;
      end else if (instr == IR_ISC_DIS) begin
        isc_active <= 1'b0;
      end
    end
  end

  always_comb begin
    isc_cmd = (instr == IR_ISC_NOOP) || (instr == IR_ISC_PROG) ||
              (instr == IR_ISC_PUC);
    unique case (instr)
      IR_IDCODE:   path = PATH_ID;
      IR_USERCODE: path = PATH_USER;
      IR_ISC_NOOP: path = isc_active ? PATH_NOOP : PATH_BYP;
      IR_ISC_PROG: path = isc_active ? PATH_NOOP : PATH_BYP;
      IR_ISC_PUC:  path = isc_active ? PATH_USER : PATH_BYP;
      default:     path = PATH_BYP;
    endcase
    ucode_wr_ok = isc_active && (instr == IR_ISC_PUC);
    pads_d      = isc_active && isc_cmd;
    prog_d      = isc_active && (instr == IR_ISC_PROG);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pads_q <= 1'b0;
      prog_q <= 1'b0;
    end else begin
      pads_q <= pads_d;
      prog_q <= prog_d;
    end
  end
endmodule

// File: rtl/isc_bit_stage.sv
module isc_bit_stage (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic capture,
  input  logic shift,
  input  logic tdi,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else if (sel && capture) begin
      q <= 1'b0;
    end else if (sel && shift) begin
      q <= tdi;
    end
  end
endmodule

// File: rtl/isc_code_chain.sv
module isc_code_chain #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel,
  input  logic         capture,
  input  logic         shift,
  input  logic         tdi,
  input  logic [W-1:0] cap_val,
  output logic [W-1:0] chain
);
  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else if (sel && capture) begin
      chain <= cap_val;
    end else if (sel && shift) begin
      chain <= {tdi, chain[W-1:1]};
    end
  end
endmodule

// File: rtl/isc_ucode_store.sv
module isc_ucode_store #(
  parameter int           W    = 32,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= INIT;
    end else if (wr) begin
      q <= din;
    end
  end
endmodule

// File: rtl/isc_tap_dr_sel.sv
module isc_tap_dr_sel
  import isc_pkg::*;
#(
  parameter int                ID_W     = 32,
  parameter int                MFR_LSB  = 1,
  parameter int                MFR_W    = 11,
  parameter logic [ID_W-1:0]   ID_VALUE = 32'h1234_50F3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ir_upd,
  input  logic [IR_W-1:0] instr,
  input  logic            capture_dr,
  input  logic            shift_dr,
  input  logic            update_dr,
  input  logic            tdi,
  output logic            tdo,
  output logic            bsr_owns_pads,
  output logic            prog_en
);
  localparam logic [ID_W-1:0] MFR_MASK =
    {{(ID_W-MFR_W){1'b0}}, {MFR_W{1'b1}}} << MFR_LSB;
  localparam logic [ID_W-1:0] UC_INIT = ID_VALUE & ~MFR_MASK;

  path_e           path;
  logic            isc_active, ucode_wr_ok;
  logic            byp_q, noop_q;
  logic [ID_W-1:0] id_chain, uc_chain, ucode_q;

  isc_instr_decode u_dec (
    .clk(clk), .rst(rst), .ir_upd(ir_upd), .instr(instr),
    .path(path), .isc_active(isc_active), .ucode_wr_ok(ucode_wr_ok),
    .pads_q(bsr_owns_pads), .prog_q(prog_en)
  );

  isc_bit_stage u_byp (
    .clk(clk), .rst(rst), .sel(path == PATH_BYP),
    .capture(capture_dr), .shift(shift_dr), .tdi(tdi), .q(byp_q)
  );

  isc_bit_stage u_noop (
    .clk(clk), .rst(rst), .sel(path == PATH_NOOP),
    .capture(capture_dr), .shift(shift_dr), .tdi(tdi), .q(noop_q)
  );

  isc_code_chain #(.W(ID_W)) u_id (
    .clk(clk), .rst(rst), .sel(path == PATH_ID),
    .capture(capture_dr), .shift(shift_dr), .tdi(tdi),
    .cap_val(ID_VALUE), .chain(id_chain)
  );

  isc_code_chain #(.W(ID_W)) u_uc (
    .clk(clk), .rst(rst), .sel(path == PATH_USER),
    .capture(capture_dr), .shift(shift_dr), .tdi(tdi),
    .cap_val(ucode_q), .chain(uc_chain)
  );

  isc_ucode_store #(.W(ID_W), .INIT(UC_INIT)) u_store (
    .clk(clk), .rst(rst), .wr(update_dr && ucode_wr_ok),
    .din(uc_chain), .q(ucode_q)
  );

  always_comb begin
    unique case (path)
      PATH_NOOP: tdo = noop_q;
      PATH_ID:   tdo = id_chain[0];
      PATH_USER: tdo = uc_chain[0];
      default:   tdo = byp_q;
    endcase
  end
endmodule

// File: rtl/isc_tap_dr_sel_chk.sv
module isc_tap_dr_sel_chk
  import isc_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = '0
) (
  input logic            clk,
  input logic            rst,
  input logic            ir_upd,
  input logic [IR_W-1:0] instr,
  input logic            capture_dr,
  input logic            update_dr,
  input logic            bsr_owns_pads,
  input logic            prog_en,
  input logic            isc_active,
  input logic [1:0]      path,
  input logic            byp_q,
  input logic [ID_W-1:0] id_chain,
  input logic [ID_W-1:0] ucode_q
);
  a_r6_enable_opens: assert property (@(posedge clk) disable iff (rst)
    (ir_upd && instr == IR_ISC_EN) |=> isc_active);

  a_r6_disable_closes: assert property (@(posedge clk) disable iff (rst)
    (ir_upd && instr == IR_ISC_DIS) |=> !isc_active);

  a_r9_prog_needs_open: assert property (@(posedge clk) disable iff (rst)
    prog_en |-> ($past(isc_active) && $past(instr) == IR_ISC_PROG));

  a_r10_pads_need_open: assert property (@(posedge clk) disable iff (rst)
    bsr_owns_pads |-> $past(isc_active));

  a_r4_store_write_gated: assert property (@(posedge clk) disable iff (rst)
    !$stable(ucode_q) |-> ($past(update_dr) && $past(isc_active)));

  a_r2_id_capture: assert property (@(posedge clk) disable iff (rst)
    (capture_dr && path == 2'd2) |=> (id_chain == ID_VALUE));

  a_r8_bypass_capture_zero: assert property (@(posedge clk) disable iff (rst)
    (capture_dr && path == 2'd0) |=> !byp_q);

  a_r9_prog_implies_pads: assert property (@(posedge clk) disable iff (rst)
    prog_en |-> bsr_owns_pads);
endmodule

bind isc_tap_dr_sel isc_tap_dr_sel_chk #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_chk (
  .clk(clk), .rst(rst), .ir_upd(ir_upd), .instr(instr),
  .capture_dr(capture_dr), .update_dr(update_dr),
  .bsr_owns_pads(bsr_owns_pads), .prog_en(prog_en),
  .isc_active(isc_active), .path(path), .byp_q(byp_q),
  .id_chain(id_chain), .ucode_q(ucode_q)
);

// File: tb/test_isc_tap_dr_sel.sv
module test_isc_tap_dr_sel;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ir_upd = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
  logic tdi = 1'b0;
  logic [3:0] instr = 4'hF;
  logic tdo, bsr_owns_pads, prog_en;
  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  localparam logic [31:0] ID_EXP = 32'h1234_50F3;
  localparam logic [31:0] UC_DEF = 32'h1234_5001;
  localparam logic [31:0] UC_NEW = 32'hCAFE_BABE;

  // {instr[3:0], open, exp_pads, exp_prog, one_bit_path}
  localparam int NV = 10;
  localparam logic [7:0] VEC [NV] = '{
    8'h10, 8'h20, 8'h51, 8'h5D, 8'h61, 8'h6F, 8'h7C, 8'hF9, 8'hA9, 8'h71
  };

  always #10 clk = ~clk;

  isc_tap_dr_sel i_isc_tap_dr_sel (
    .clk(clk), .rst(rst), .ir_upd(ir_upd), .instr(instr),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .tdo(tdo), .bsr_owns_pads(bsr_owns_pads), .prog_en(prog_en)
  );

  task automatic check(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe_cap();
    capture_dr = 1'b1; @(negedge clk); capture_dr = 1'b0;
  endtask

  task automatic strobe_shift(input logic b);
    tdi = b; shift_dr = 1'b1; @(negedge clk); shift_dr = 1'b0;
  endtask

  task automatic strobe_upd();
    update_dr = 1'b1; @(negedge clk); update_dr = 1'b0;
  endtask

  task automatic set_open(input logic o);
    instr = o ? 4'h3 : 4'h4;
    ir_upd = 1'b1; @(negedge clk); ir_upd = 1'b0;
  endtask

  task automatic read_chain(output logic [31:0] v);
    strobe_cap();
    for (int i = 0; i < 32; i++) begin
      v[i] = tdo;
      strobe_shift(1'b0);
    end
  endtask

  task automatic write_chain(input logic [31:0] v);
    strobe_cap();
    for (int i = 0; i < 32; i++) strobe_shift(v[i]);
    strobe_upd();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!prog_en, "R1 prog_en", {31'b0, prog_en}, 0);
    check(!bsr_owns_pads, "R1 pads", {31'b0, bsr_owns_pads}, 0);
    instr = 4'h7; @(negedge clk);
    check(!bsr_owns_pads, "R1 closed after reset", {31'b0, bsr_owns_pads}, 0);

    // table walk: R6 R7 R8 R9 R10
    for (int k = 0; k < NV; k++) begin
      logic [7:0] v;
      v = VEC[k];
      set_open(v[3]);
      instr = v[7:4];
      @(negedge clk);
      check(bsr_owns_pads == v[2], "R10 pads per code", {31'b0, bsr_owns_pads}, {31'b0, v[2]});
      check(prog_en == v[1], "R9 prog per code", {31'b0, prog_en}, {31'b0, v[1]});
      if (v[0]) begin
        strobe_cap();
        check(tdo == 1'b0, "R8 R7 one-bit capture", {31'b0, tdo}, 0);
        strobe_shift(1'b1);
        check(tdo == 1'b1, "R8 R7 one-bit shift 1", {31'b0, tdo}, 1);
        strobe_shift(1'b0);
        check(tdo == 1'b0, "R8 R7 one-bit shift 0", {31'b0, tdo}, 0);
      end
    end

    // R2 identification read
    instr = 4'h1; @(negedge clk);
    read_chain(rd);
    check(rd == ID_EXP, "R2 idcode", rd, ID_EXP);
    check(rd[0] == 1'b1, "R2 bit0", {31'b0, rd[0]}, 1);

    // R3 default user code
    instr = 4'h2; @(negedge clk);
    read_chain(rd);
    check(rd == UC_DEF, "R3 default usercode", rd, UC_DEF);

    // R5 write while closed is discarded
    set_open(1'b0);
    instr = 4'h7; @(negedge clk);
    write_chain(UC_NEW);
    instr = 4'h2; @(negedge clk);
    read_chain(rd);
    check(rd == UC_DEF, "R5 closed write ignored", rd, UC_DEF);

    // R4 write while open
    set_open(1'b1);
    instr = 4'h7; @(negedge clk);
    write_chain(UC_NEW);
    instr = 4'h2; @(negedge clk);
    read_chain(rd);
    check(rd == UC_NEW, "R4 usercode written", rd, UC_NEW);

    // R6 disable closes: program code no longer effective
    set_open(1'b0);
    instr = 4'h6; @(negedge clk);
    check(!prog_en, "R6 prog after disable", {31'b0, prog_en}, 0);
    check(!bsr_owns_pads, "R6 pads after disable", {31'b0, bsr_owns_pads}, 0);
    set_open(1'b1);
    instr = 4'h6; @(negedge clk);
    check(prog_en, "R6 prog after re-enable", {31'b0, prog_en}, 1);

    // R1 reset restores the default user code
    rst = 1'b1; @(negedge clk); @(negedge clk); rst = 1'b0;
    check(!prog_en, "R1 prog after reset", {31'b0, prog_en}, 0);
    instr = 4'h2; @(negedge clk);
    read_chain(rd);
    check(rd == UC_DEF, "R1 usercode after reset", rd, UC_DEF);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule